// File: doc/BRIEF.md
# Two-Key Register Write Unlock Gate

This block protects a peripheral's configuration registers against stray writes. After reset the gate is locked: a write strobe aimed at the protected address window is swallowed and never reaches the registers behind it. Software opens the gate by writing two 32-bit magic values, each to its own key register. The first key must go in before the second. Once the gate is open it stays open until the next reset.

The gate snoops the register bus write channel: address, data and a single-cycle write enable. It does not reshape the channel. The address and data go straight on to the protected registers. Only the write enable is filtered, so the filtered strobe can be used by those registers in the same cycle. The gate state shows up in one bit of the general control register read word, which software polls to confirm the unlock. The same state is also driven on a dedicated output.

Top module: `unlock_gate`

## Requirements
- R1: During reset and in the first cycle after reset the gate is locked: `unlocked` is 0, `prot_wr_en` is 0, and the status bit reads back 0.
- R2: A write of 0x83E70B13 to offset 0x70, followed by a write of 0x95A4F1E0 to offset 0x74, sets `unlocked` to 1 in the cycle after the 0x74 write.
- R3: A write to offset 0x74 that is not preceded by a correct key at 0x70 leaves the gate locked, even when it carries the correct value.
- R4: A wrong value written to offset 0x70 returns the gate to locked. A wrong value written to offset 0x74 while the gate waits for the second key also returns it to locked. After either, the second key alone no longer unlocks the gate.
- R5: While the gate is locked, a write anywhere in the protected window 0x00 to 0x6C produces no `prot_wr_en`.
- R6: While the gate is unlocked, a write in the protected window raises `prot_wr_en` in the same cycle as `wr_en`. Writes to the key offsets 0x70/0x74, and writes outside the window, never raise `prot_wr_en`.
- R7: Once unlocked, the gate stays unlocked until reset, whatever values are later written to either key offset.
- R8: With `rd_addr` equal to 0x50, `rd_data` bit 23 equals the unlock state and all other bits are 0. Any other `rd_addr` returns 0.
- R9: Writes to non-key offsets between the first and second key do not disturb the sequence.
- R10: Rewriting the correct first key while waiting for the second key keeps the gate waiting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe from the register bus |
| wr_addr | input | 12 | Byte offset of the write |
| wr_data | input | 32 | Write data |
| prot_wr_en | output | 1 | Filtered write strobe to the protected registers |
| rd_addr | input | 12 | Byte offset of the status read |
| rd_data | output | 32 | Status read word (unlock bit at bit 23 of offset 0x50) |
| unlocked | output | 1 | Gate state, 1 when writes are allowed |

## Verification
The hardest state to reach from the ports is the waiting state with something unusual happening in it. Examples are a wrong second key, a repeated first key, or unrelated writes in the gap between the two keys. None of these is visible on any output until the second key arrives. The directed tasks therefore walk into the waiting state with a correct first key, apply the disturbance, and then end with a correct second key. The resulting unlock state, read both on `unlocked` and through the status word, shows which state the gate was really in.

// File: rtl/unlock_pkg.sv
// Shared types for the two-key write unlock gate.
// Assumes: single clock domain, one write per cycle at most.
package unlock_pkg;

    // Sequence position of the gate.
    typedef enum logic [1:0] {
        GATE_LOCKED = 2'd0,
        GATE_ARMED  = 2'd1,
        GATE_OPEN   = 2'd2
    } gate_state_t;

    // Decoded key-register activity for one bus cycle.
    typedef struct packed {
        logic hit0;   // write to first key offset
        logic good0;  // ...carrying the first magic value
        logic hit1;   // write to second key offset
        logic good1;  // ...carrying the second magic value
    } key_ev_t;

endpackage

// File: rtl/key_match.sv
// Decodes bus writes aimed at the two key registers and compares the
// data against the magic values. Purely combinational.
// Assumes: wr_en is a one-cycle strobe qualified by the bus.
module key_match
    import unlock_pkg::*;
#(
    parameter int                ADDR_W    = 12,
    parameter int                DATA_W    = 32,
    parameter logic [ADDR_W-1:0] KEY0_ADDR = 12'h070,
    parameter logic [ADDR_W-1:0] KEY1_ADDR = 12'h074,
    parameter logic [DATA_W-1:0] KEY0_VAL  = 32'h83E7_0B13,
    parameter logic [DATA_W-1:0] KEY1_VAL  = 32'h95A4_F1E0
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output key_ev_t           ev,
    output logic              any_key
);

    // Address and value compare for both keys.
    always_comb begin
        ev.hit0  = wr_en && (wr_addr == KEY0_ADDR);
        ev.hit1  = wr_en && (wr_addr == KEY1_ADDR);
        ev.good0 = ev.hit0 && (wr_data == KEY0_VAL);
        ev.good1 = ev.hit1 && (wr_data == KEY1_VAL);
        any_key  = (wr_addr == KEY0_ADDR) || (wr_addr == KEY1_ADDR);
    end

endmodule

// File: rtl/unlock_seq.sv
// Three-state sequencer: LOCKED -> ARMED on a good first key,
// ARMED -> OPEN on a good second key; any other key write falls back
// to LOCKED. OPEN is sticky until reset.
// Assumes: ev is decoded from the same cycle's bus write.
module unlock_seq
    import unlock_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  key_ev_t ev,
    output logic    unlocked
);

    gate_state_t state_q, state_d;

    // Next-state selection from key events.
    always_comb begin
        state_d = state_q;
        case (state_q)
            GATE_LOCKED: begin
                if (ev.good0)
                    state_d = GATE_ARMED;
            end
            GATE_ARMED: begin
                if (ev.good1)
                    state_d = GATE_OPEN;
                else if (ev.hit1 || (ev.hit0 && !ev.good0))
                    state_d = GATE_LOCKED;
            end
            GATE_OPEN:   state_d = GATE_OPEN;
            default:     state_d = GATE_LOCKED;
        endcase
    end

    // State register with synchronous reset to locked.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= GATE_LOCKED;
        else
            state_q <= state_d;
    end

    assign unlocked = (state_q == GATE_OPEN);

endmodule

// File: rtl/write_filter.sv
// Passes the bus write strobe to the protected window only when the
// gate is open. Key offsets and addresses outside the window are
// never forwarded.
// Assumes: PROT_LO <= PROT_HI and the key offsets lie outside or are
// excluded explicitly via is_key.
module write_filter #(
    parameter int                ADDR_W  = 12,
    parameter logic [ADDR_W-1:0] PROT_LO = 12'h000,
    parameter logic [ADDR_W-1:0] PROT_HI = 12'h06C
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              is_key,
    input  logic              unlocked,
    output logic              prot_wr_en
);

    logic in_window;

    // Window decode and gating of the strobe.
    always_comb begin
        in_window  = (wr_addr >= PROT_LO) && (wr_addr <= PROT_HI);
        prot_wr_en = wr_en && in_window && !is_key && unlocked;
    end

endmodule

// File: rtl/status_port.sv
// Builds the general control read word: only the unlock bit is owned
// here, every other bit reads 0.
// Assumes: the read is combinational from rd_addr.
module status_port #(
    parameter int                ADDR_W    = 12,
    parameter int                DATA_W    = 32,
    parameter logic [ADDR_W-1:0] STAT_ADDR = 12'h050,
    parameter int                STAT_BIT  = 23
) (
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              unlocked,
    output logic [DATA_W-1:0] rd_data
);

    // Place the unlock bit when the status offset is addressed.
    always_comb begin
        rd_data = '0;
        if (rd_addr == STAT_ADDR)
            rd_data[STAT_BIT] = unlocked;
    end

endmodule

// File: rtl/unlock_gate.sv
// Top of the two-key write unlock gate: key decode, sequencer,
// strobe filter and status read word.
// Assumes: synchronous active-low reset, single clock.
module unlock_gate
    import unlock_pkg::*;
#(
    parameter int                ADDR_W    = 12,
    parameter int                DATA_W    = 32,
    parameter logic [ADDR_W-1:0] KEY0_ADDR = 12'h070,
    parameter logic [ADDR_W-1:0] KEY1_ADDR = 12'h074,
    parameter logic [DATA_W-1:0] KEY0_VAL  = 32'h83E7_0B13,
    parameter logic [DATA_W-1:0] KEY1_VAL  = 32'h95A4_F1E0,
    parameter logic [ADDR_W-1:0] STAT_ADDR = 12'h050,
    parameter int                STAT_BIT  = 23,
    parameter logic [ADDR_W-1:0] PROT_LO   = 12'h000,
    parameter logic [ADDR_W-1:0] PROT_HI   = 12'h06C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              prot_wr_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              unlocked
);

    key_ev_t key_ev;
    logic    is_key;

    key_match #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .KEY0_ADDR(KEY0_ADDR), .KEY1_ADDR(KEY1_ADDR),
        .KEY0_VAL(KEY0_VAL), .KEY1_VAL(KEY1_VAL)
    ) u_match (
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .ev(key_ev), .any_key(is_key)
    );

    unlock_seq u_seq (
        .clk(clk), .rst_n(rst_n), .ev(key_ev), .unlocked(unlocked)
    );

    write_filter #(
        .ADDR_W(ADDR_W), .PROT_LO(PROT_LO), .PROT_HI(PROT_HI)
    ) u_filter (
        .wr_en(wr_en), .wr_addr(wr_addr), .is_key(is_key),
        .unlocked(unlocked), .prot_wr_en(prot_wr_en)
    );

    status_port #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .STAT_ADDR(STAT_ADDR), .STAT_BIT(STAT_BIT)
    ) u_status (
        .rd_addr(rd_addr), .unlocked(unlocked), .rd_data(rd_data)
    );

endmodule

// File: rtl/unlock_gate_chk.sv
// Property checker for unlock_gate, attached by bind.
// Assumes: same parameter values as the bound instance.
module unlock_gate_chk #(
    parameter int                ADDR_W    = 12,
    parameter int                DATA_W    = 32,
    parameter logic [ADDR_W-1:0] KEY0_ADDR = 12'h070,
    parameter logic [ADDR_W-1:0] KEY1_ADDR = 12'h074,
    parameter logic [DATA_W-1:0] KEY1_VAL  = 32'h95A4_F1E0,
    parameter logic [ADDR_W-1:0] STAT_ADDR = 12'h050,
    parameter int                STAT_BIT  = 23
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              prot_wr_en,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [DATA_W-1:0] rd_data,
    input logic              unlocked
);

    AST_RESET_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !unlocked); // R1

    AST_OPEN_BY_KEY1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(unlocked) |-> $past(wr_en && wr_addr == KEY1_ADDR && wr_data == KEY1_VAL)); // R2

    AST_LOCKED_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !unlocked |-> !prot_wr_en); // R5

    AST_KEY_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_addr == KEY0_ADDR || wr_addr == KEY1_ADDR) |-> !prot_wr_en); // R6

    AST_STICKY_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        unlocked |=> unlocked); // R7

    AST_STATUS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == STAT_ADDR) |-> (rd_data[STAT_BIT] == unlocked &&
                                    $countones(rd_data) <= 1)); // R8

endmodule

bind unlock_gate unlock_gate_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .KEY0_ADDR(KEY0_ADDR), .KEY1_ADDR(KEY1_ADDR), .KEY1_VAL(KEY1_VAL),
    .STAT_ADDR(STAT_ADDR), .STAT_BIT(STAT_BIT)
) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .prot_wr_en(prot_wr_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .unlocked(unlocked)
);

// File: tb/unlock_gate_tb.sv
module unlock_gate_tb;

    localparam logic [31:0] K0 = 32'h83E7_0B13;
    localparam logic [31:0] K1 = 32'h95A4_F1E0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [11:0] wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [11:0] rd_addr = '0;
    logic        prot_wr_en;
    logic [31:0] rd_data;
    logic        unlocked;

    int total = 0;
    int bad = 0;
    logic last_strobe;

    always #5 clk = ~clk;

    unlock_gate u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .prot_wr_en(prot_wr_en), .rd_addr(rd_addr),
        .rd_data(rd_data), .unlocked(unlocked)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        wr_en = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // One bus write; strobe captured inside the write cycle.
    task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        #1 last_strobe = prot_wr_en;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic read_stat(output logic [31:0] v);
        rd_addr = 12'h050;
        #1 v = rd_data;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        do_reset();
        check("R1 unlocked", {31'd0, unlocked}, 32'd0);
        check("R1 strobe", {31'd0, prot_wr_en}, 32'd0);
        read_stat(v);
        check("R1 status", v, 32'd0);
    endtask

    task automatic t_basic_unlock();
        logic [31:0] v;
        do_reset();
        bus_wr(12'h070, K0);
        check("R2 after key0", {31'd0, unlocked}, 32'd0);
        bus_wr(12'h074, K1);
        check("R2 after key1", {31'd0, unlocked}, 32'd1);
        read_stat(v);
        check("R8 status open", v, 32'h0080_0000);
        rd_addr = 12'h054;
        #1 check("R8 other addr", rd_data, 32'd0);
    endtask

    task automatic t_key1_first();
        do_reset();
        bus_wr(12'h074, K1);
        check("R3 key1 alone", {31'd0, unlocked}, 32'd0);
        bus_wr(12'h074, K1);
        check("R3 key1 twice", {31'd0, unlocked}, 32'd0);
        bus_wr(12'h070, K0);
        bus_wr(12'h074, K1);
        check("R3 recover", {31'd0, unlocked}, 32'd1);
    endtask

    task automatic t_wrong_keys();
        do_reset();
        bus_wr(12'h070, K0 ^ 32'h1);
        bus_wr(12'h074, K1);
        check("R4 bad key0", {31'd0, unlocked}, 32'd0);
        bus_wr(12'h070, K0);
        bus_wr(12'h074, K1 ^ 32'h8000_0000);
        bus_wr(12'h074, K1);
        check("R4 bad key1", {31'd0, unlocked}, 32'd0);
        bus_wr(12'h070, K0);
        bus_wr(12'h070, 32'h0);
        bus_wr(12'h074, K1);
        check("R4 armed then bad key0", {31'd0, unlocked}, 32'd0);
    endtask

    task automatic t_locked_writes();
        do_reset();
        bus_wr(12'h000, 32'h1);
        check("R5 low edge", {31'd0, last_strobe}, 32'd0);
        bus_wr(12'h050, 32'hFFFF_FFFF);
        check("R5 status offset", {31'd0, last_strobe}, 32'd0);
        bus_wr(12'h06C, 32'h5);
        check("R5 high edge", {31'd0, last_strobe}, 32'd0);
    endtask

    task automatic t_open_writes();
        do_reset();
        bus_wr(12'h070, K0);
        bus_wr(12'h074, K1);
        bus_wr(12'h000, 32'h1);
        check("R6 low edge", {31'd0, last_strobe}, 32'd1);
        bus_wr(12'h06C, 32'h2);
        check("R6 high edge", {31'd0, last_strobe}, 32'd1);
        bus_wr(12'h070, 32'h3);
        check("R6 key0 offset", {31'd0, last_strobe}, 32'd0);
        bus_wr(12'h074, 32'h4);
        check("R6 key1 offset", {31'd0, last_strobe}, 32'd0);
        bus_wr(12'h078, 32'h5);
        check("R6 outside", {31'd0, last_strobe}, 32'd0);
        check("R7 sticky after key junk", {31'd0, unlocked}, 32'd1);
        bus_wr(12'h070, K0);
        bus_wr(12'h074, 32'h0);
        check("R7 sticky after bad key1", {31'd0, unlocked}, 32'd1);
        do_reset();
        check("R7 reset relocks", {31'd0, unlocked}, 32'd0);
    endtask

    task automatic t_gap_writes();
        do_reset();
        bus_wr(12'h070, K0);
        bus_wr(12'h010, 32'hDEAD_BEEF);
        bus_wr(12'h100, K1);
        bus_wr(12'h074, K1);
        check("R9 gap writes", {31'd0, unlocked}, 32'd1);
    endtask

    task automatic t_repeat_key0();
        do_reset();
        bus_wr(12'h070, K0);
        bus_wr(12'h070, K0);
        bus_wr(12'h070, K0);
        bus_wr(12'h074, K1);
        check("R10 repeated key0", {31'd0, unlocked}, 32'd1);
    endtask

    initial begin
        #2_000_000;
        bad++;
        total++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_basic_unlock();
        t_key1_first();
        t_wrong_keys();
        t_locked_writes();
        t_open_writes();
        t_gap_writes();
        t_repeat_key0();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule